// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers up to eight event inputs into one byte-wide register. A write to the register's address sets the enable mask for the sources. A read at the same address returns which enabled sources have seen a rising edge. Each status bit stays set until software removes that source's enable. The block has no separate acknowledge path, so a handler works in three steps: it reads the status, writes the mask back with the seen sources cleared, and then writes the full mask again.

A parameter names the sources that exist. Bits outside that set cannot be enabled, never latch, and read as zero. A registered interrupt request is high while any status bit is set. A source whose enable is still set keeps latching edges while other sources are masked for service. A new edge therefore shows up on a later read.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset all enables and status bits are 0, irq_o is low and a read at the register address returns 0.
- R2: A cycle with wr_i high and addr_i equal to REG_ADDR (default 0x1E) loads the enable mask with wr_data_i AND VALID_MASK (default 0xB7). A read at that address returns the status byte, bit i for source i. Bits outside VALID_MASK never set and read 0.
- R3: A rising edge on an enabled source sets that source's status bit at the next clock edge. A rising edge is src_i[i] high in this cycle and low in the previous cycle.
- R4: A write that clears an enable bit clears that source's status bit at the same clock edge. Writing 0 clears all status.
- R5: irq_o rises one clock after any status bit becomes set. It falls one clock after all status bits are clear.
- R6: A rising edge that arrives in the same cycle as a register write is latched only if the newly written enable bit of that source is 1.
- R7: Status bits are sticky while enabled, and further edges do not queue. After a source is disabled and enabled again, its status stays 0 until a new rising edge.
- R8: A write with addr_i not equal to REG_ADDR leaves enables and status unchanged. A read at any other address returns 0.
- R9: While some sources are masked for service, the other enabled sources still latch edges, and rewriting the full mask keeps those new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address for both read and write |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_SRC | Enable mask to write |
| rd_data_o | output | NUM_SRC | Status byte, combinational from addr_i |
| src_i | input | NUM_SRC | Event inputs, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Edge capture and a mask write can land on the same clock edge. The new enable decides whether the edge counts, and a cleared enable must also wipe any older status. The bench provokes this directly, with one edge arriving alongside a write that enables its source and another alongside a write that leaves its source disabled. The random phase then overlaps writes with edges on many cycles. Each outcome is judged against a bench model that applies the written mask before it folds in the edge.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam int unsigned DEF_NUM_SRC = 8;
  localparam int unsigned DEF_ADDR_W  = 5;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } dec_t;
endpackage

// File: rtl/intsrc_dec.sv
module intsrc_dec
  import intsrc_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(5'h1E)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output dec_t              dec_o
);
  logic match;
  assign match        = (addr_i == REG_ADDR);
  assign dec_o.rd_hit = match;
  assign dec_o.wr_hit = match & wr_i;
endmodule

// File: rtl/intsrc_edge.sv
module intsrc_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/intsrc_cell.sv
module intsrc_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hit_i,
  input  logic wr_bit_i,
  input  logic rise_i,
  output logic en_o,
  output logic st_o
);
  logic en_q, st_q, en_n, st_n;

  // new enable applies before the edge is folded in
  assign en_n = wr_hit_i ? wr_bit_i : en_q;
  assign st_n = en_n & (st_q | rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      en_q <= en_n;
      st_q <= st_n;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;
endmodule

// File: rtl/intsrc_irq.sv
module intsrc_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] st_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |st_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
  import intsrc_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]  REG_ADDR   = ADDR_W'(5'h1E),
  parameter logic [NUM_SRC-1:0] VALID_MASK = NUM_SRC'(8'hB7)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  dec_t               dec;
  logic               wr_hit;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] st_q;

  intsrc_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .dec_o  (dec)
  );
  assign wr_hit = dec.wr_hit;

  intsrc_edge #(.N(NUM_SRC)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (VALID_MASK[i]) begin : g_valid
      intsrc_cell cell_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_hit_i (wr_hit),
        .wr_bit_i (wr_data_i[i]),
        .rise_i   (rise[i]),
        .en_o     (en_q[i]),
        .st_o     (st_q[i])
      );
    end else begin : g_absent
      logic unused_bits;
      assign unused_bits = wr_data_i[i] ^ rise[i];
      assign en_q[i] = 1'b0;
      assign st_q[i] = 1'b0;
    end
  end

  intsrc_irq #(.N(NUM_SRC)) irq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st_q),
    .irq_o  (irq_o)
  );

  assign rd_data_o = dec.rd_hit ? st_q : '0;
endmodule

// File: rtl/intsrc_ctrl_chk.sv
module intsrc_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] VALID_MASK = NUM_SRC'(8'hB7)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_hit_i,
  input logic [NUM_SRC-1:0] wr_data_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] st_i,
  input logic [NUM_SRC-1:0] rise_i,
  input logic               irq_i
);
  a_r2_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i & ~VALID_MASK) == '0);

  a_r3_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> ((st_i & $past(en_i & rise_i)) == $past(en_i & rise_i)));

  a_r4_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> ((st_i & ~$past(wr_data_i)) == '0));

  a_r5_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != '0) |=> irq_i);

  a_r5_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == '0) |=> !irq_i);

  a_r6_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> ((st_i & $past(wr_data_i & VALID_MASK & rise_i))
                  == $past(wr_data_i & VALID_MASK & rise_i)));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> ((st_i & $past(st_i)) == $past(st_i)));
endmodule

bind intsrc_ctrl intsrc_ctrl_chk #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_hit_i  (wr_hit),
  .wr_data_i (wr_data_i),
  .en_i      (en_q),
  .st_i      (st_q),
  .rise_i    (rise),
  .irq_i     (irq_o)
);

// File: tb/intsrc_ctrl_tb_top.sv
`timescale 1ns/1ps
module intsrc_ctrl_tb_top;
  localparam logic [7:0] VALID = 8'hB7;
  localparam logic [4:0] RADDR = 5'h1E;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr_i = RADDR;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] src_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic [7:0] m_en = '0, m_st = '0, m_prev = '0;
  logic       m_irq = 1'b0;

  always #4 clk_i = ~clk_i;

  intsrc_ctrl dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .src_i     (src_i),
    .irq_o     (irq_o)
  );

  function automatic logic [7:0] exp_rd(logic [4:0] a, logic [7:0] st);
    return (a == RADDR) ? st : 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, cross one posedge, update model, check at next negedge
  task automatic step(logic w, logic [7:0] d, logic [4:0] a, logic [7:0] s, string tag);
    logic [7:0] rise, en_n, st_n;
    wr_i = w; wr_data_i = d; addr_i = a; src_i = s;
    @(posedge clk_i);
    rise  = s & ~m_prev;
    en_n  = (w && a == RADDR) ? (d & VALID) : m_en;
    st_n  = (m_st | (rise & en_n)) & en_n;
    m_irq = |m_st;
    m_st  = st_n;
    m_en  = en_n;
    m_prev = s;
    @(negedge clk_i);
    chk({tag, " rd"}, rd_data_o, exp_rd(a, m_st));
    chk({tag, " irq"}, {7'b0, irq_o}, {7'b0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    step(1, 8'hFF, RADDR, 8'h00, "R2");       // enables only valid bits
    step(0, 8'h00, RADDR, 8'hFF, "R2");       // all edges, status B7, irq not yet
    step(0, 8'h00, RADDR, 8'hFF, "R5");       // irq one cycle later
    step(0, 8'h00, RADDR, 8'h00, "R7");       // sticky after inputs fall
    step(0, 8'h00, RADDR, 8'h01, "R7");       // repeat edge, no change
    step(1, 8'hB6, RADDR, 8'h00, "R4");       // clear source 0
    step(1, 8'h00, RADDR, 8'h00, "R4");       // clear all
    step(0, 8'h00, RADDR, 8'h00, "R5");       // irq falls
    step(1, 8'h01, RADDR, 8'h01, "R6");       // edge with new enable 1: captured
    step(1, 8'h00, RADDR, 8'h01, "R4");
    step(0, 8'h00, RADDR, 8'h03, "R3");       // edge on disabled source ignored
    step(1, 8'h01, RADDR, 8'h07, "R6");       // edge on src2 with new enable 0
    step(1, 8'hB7, RADDR, 8'h06, "R7");       // re-enable: no stale status
    step(0, 8'h00, RADDR, 8'h07, "R3");       // src0 edge
    step(1, 8'hB6, RADDR, 8'h07, "R9");       // mask seen source
    step(0, 8'h00, RADDR, 8'h27, "R9");       // src5 still latches
    step(1, 8'hB7, RADDR, 8'h27, "R9");       // full mask rewrite keeps it
    step(1, 8'h00, 5'h1D,  8'h27, "R8");      // foreign address write, read 0
    step(0, 8'h00, RADDR, 8'h27, "R8");       // status intact
    step(0, 8'h00, RADDR, 8'hA7, "R8");       // enable intact: src7 latches

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a;
      a = ($urandom_range(7) == 0) ? 5'($urandom_range(31)) : RADDR;
      step(($urandom_range(3) == 0), 8'($urandom), a,
           8'($urandom) & 8'($urandom), "R3/R4/R6 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule